// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block sits on the device side of an asynchronous-strobe DRAM and watches the four active-low strobes (row strobe, column strobe, write enable, output enable). It samples them on a fast internal clock and finds their edges by comparing each sample with the one before. From the order of those edges it names each memory cycle: read, early write, late write or read-modify-write, row-only refresh, column-before-row refresh, hidden refresh, or test-mode entry. The name is reported as a one-clock event code.

The block also owns three pieces of state. The first is the internal refresh row counter, which supplies the row for counter-driven refreshes. The second is a sticky test-mode flag that only particular refresh cycles can clear. The third is the enable for the data output drivers. A memory array uses the event code and refresh row to decide what to sense, write back or refresh.

Every output is registered. A decision shows up in the clock after the sample that first holds the strobe edge behind it.

Top module: `dramCycleDecoder`

## Requirements
- R1: After reset the event code is 0 (none), the output enable is 0, the refresh row is 0, the internal counter is 0 and the test flag equals the TEST_ON_RESET parameter (default 1).
- R2: Row strobe falling with column strobe high opens a row. A later column strobe fall with write enable high in the previous sample gives event code 1 (read), and the output enable goes to 1 while output enable is low.
- R3: If write enable was already low in the sample before the column strobe fall inside an open row, the event is code 2 (early write) and the output enable stays 0 for the whole column cycle, whatever output enable does.
- R4: A write-enable fall while the column strobe is low after a read, or in the same sample as the column strobe fall, gives code 3 (late write / read-modify-write). Read data keeps being driven while output enable is low. This event marks when write data is taken.
- R5: A row strobe rise with no column strobe fall since the row opened gives code 4 (row-only refresh), with the refresh row equal to the address sampled at the row strobe fall. The level of write enable has no effect on this.
- R6: Column strobe low when the row strobe falls, with write enable high and no read data held, gives code 5 (counter refresh). The refresh row is the counter value, and the counter then adds one.
- R7: The same strobe order while read data is still held from a read whose column strobe never rose gives code 6 (hidden refresh). It uses and advances the counter, and the output enable stays 1.
- R8: Column strobe low when the row strobe falls with write enable low gives code 7 (test entry). The test flag is set and the counter is not changed.
- R9: The test flag is cleared only by codes 4, 5 and 6. Reads and writes leave it unchanged.
- R10: The output enable is 0 whenever the previous sample had column strobe high or output enable high. Raising output enable and lowering it again while the column strobe stays low brings the read data back.
- R11: In page mode, several column strobe falls within one row give one read or early-write event each, and the closing row strobe rise gives no refresh event.
- R12: The counter wraps from 1023 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| rowAddr | input | ROW_W | Address pins, taken at the row strobe fall |
| evtType | output | 3 | One-clock cycle event code (0 = none) |
| refreshRow | output | ROW_W | Row of the last refresh event |
| testMode | output | 1 | Sticky test-mode flag |
| outEn | output | 1 | Data output driver enable |

## Verification
On every cycle the assertions check four things: the test flag rises only with a test-entry event and falls only with a refresh event, the counter steps by exactly one on each counter-driven refresh, the output enable is never on after a sample with column strobe or output enable high, and an early write never drives. Edge ordering can only be shown by the bench scenarios. These cover a write-enable fall that comes before, with, or after the column strobe fall, hidden refresh keeping data through a row strobe pulse, row-only refresh ignoring write enable, page-mode sequences, and the counter wrap. A behavioural model follows the bench every clock.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  typedef enum logic [2:0] {
    EV_NONE       = 3'd0,
    EV_READ       = 3'd1,
    EV_EARLY_WR   = 3'd2,
    EV_LATE_WR    = 3'd3,
    EV_RAS_ONLY   = 3'd4,
    EV_CBR        = 3'd5,
    EV_HIDDEN     = 3'd6,
    EV_TEST_ENTRY = 3'd7
  } evt_e;

  // Decisions passed from the strobe control to the datapath, one clock wide.
  typedef struct packed {
    logic rowLatch;
    logic rasOnly;
    logic cbr;
    logic hidden;
    logic testEnter;
    logic rd;
    logic earlyWr;
    logic lateWr;
    logic drive;
  } strobe_t;
endpackage

// File: rtl/ddcStrobeCtl.sv
module ddcStrobeCtl
  import ddc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rasN,
  input  logic    casN,
  input  logic    weN,
  input  logic    oeN,
  output strobe_t ev
);
  logic prevRas, prevCas, prevWe;
  logic rowOpen, casSeen, colRead, lateArm;
  logic rasFall, rasRise, casFall, casRise, weFall;
  logic cbrLike, colStart, colReadNext;

  always_comb begin
    rasFall  = prevRas & ~rasN;
    rasRise  = ~prevRas & rasN;
    casFall  = prevCas & ~casN;
    casRise  = ~prevCas & casN;
    weFall   = prevWe & ~weN;
    cbrLike  = rasFall & ~casN;
    colStart = casFall & rowOpen & ~rasN;

    ev.rowLatch  = rasFall & casN;
    ev.hidden    = cbrLike & weN & colRead;
    ev.cbr       = cbrLike & weN & ~colRead;
    ev.testEnter = cbrLike & ~weN;
    ev.rd        = colStart & prevWe;
    ev.earlyWr   = colStart & ~prevWe;
    // a write-enable fall in the same sample as the column fall counts as late
    ev.lateWr    = weFall & ~casN & (lateArm | ev.rd);
    ev.rasOnly   = rasRise & rowOpen & ~casSeen;

    colReadNext  = ev.rd | (colRead & ~casRise);
    ev.drive     = colReadNext & ~oeN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRas <= 1'b1;
      prevCas <= 1'b1;
      prevWe  <= 1'b1;
      rowOpen <= 1'b0;
      casSeen <= 1'b0;
      colRead <= 1'b0;
      lateArm <= 1'b0;
    end else begin
      prevRas <= rasN;
      prevCas <= casN;
      prevWe  <= weN;
      if (ev.rowLatch)  rowOpen <= 1'b1;
      else if (rasRise) rowOpen <= 1'b0;
      if (ev.rowLatch)  casSeen <= 1'b0;
      else if (colStart) casSeen <= 1'b1;
      colRead <= colReadNext;
      if (ev.lateWr | casRise) lateArm <= 1'b0;
      else if (ev.rd)          lateArm <= 1'b1;
    end
  end

  a_r3_early_never_reads: assert property (@(posedge clk) disable iff (!rstN)
    ev.earlyWr |-> !ev.drive);
endmodule

// File: rtl/ddcDataPath.sv
module ddcDataPath
  import ddc_pkg::*;
#(
  parameter int   ROW_W         = 10,
  parameter logic TEST_ON_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          ev,
  input  logic [ROW_W-1:0] rowAddr,
  output evt_e             evtType,
  output logic [ROW_W-1:0] refreshRow,
  output logic             testMode,
  output logic             outEn
);
  localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

  logic [ROW_W-1:0] refCount, rowHold;
  evt_e evtNext;

  always_comb begin
    if (ev.testEnter)     evtNext = EV_TEST_ENTRY;
    else if (ev.hidden)   evtNext = EV_HIDDEN;
    else if (ev.cbr)      evtNext = EV_CBR;
    else if (ev.lateWr)   evtNext = EV_LATE_WR;
    else if (ev.earlyWr)  evtNext = EV_EARLY_WR;
    else if (ev.rd)       evtNext = EV_READ;
    else if (ev.rasOnly)  evtNext = EV_RAS_ONLY;
    else                  evtNext = EV_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtType    <= EV_NONE;
      refreshRow <= '0;
      refCount   <= '0;
      rowHold    <= '0;
      testMode   <= TEST_ON_RESET;
      outEn      <= 1'b0;
    end else begin
      evtType <= evtNext;
      outEn   <= ev.drive;
      if (ev.rowLatch) rowHold <= rowAddr;
      if (ev.cbr | ev.hidden) begin
        refreshRow <= refCount;
        refCount   <= refCount + ONE;
      end else if (ev.rasOnly) begin
        refreshRow <= rowHold;
      end
      if (ev.testEnter) testMode <= 1'b1;
      else if (ev.rasOnly | ev.cbr | ev.hidden) testMode <= 1'b0;
    end
  end

  a_r8_test_rise_on_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testMode) |-> evtType == EV_TEST_ENTRY);
  a_r9_test_fall_on_refresh: assert property (@(posedge clk) disable iff (!rstN)
    $fell(testMode) |-> (evtType == EV_RAS_ONLY || evtType == EV_CBR || evtType == EV_HIDDEN));
  a_r6_counter_step: assert property (@(posedge clk) disable iff (!rstN)
    (evtType == EV_CBR || evtType == EV_HIDDEN) |-> refCount == $past(refCount) + ONE);
  a_r3_early_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (evtType == EV_EARLY_WR) |-> !outEn);
endmodule

// File: rtl/dramCycleDecoder.sv
module dramCycleDecoder
  import ddc_pkg::*;
#(
  parameter int   ROW_W         = 10,
  parameter logic TEST_ON_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic             oeN,
  input  logic [ROW_W-1:0] rowAddr,
  output logic [2:0]       evtType,
  output logic [ROW_W-1:0] refreshRow,
  output logic             testMode,
  output logic             outEn
);
  strobe_t ev;
  evt_e    evtQ;

  ddcStrobeCtl uCtl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN),
    .weN(weN), .oeN(oeN), .ev(ev)
  );

  ddcDataPath #(.ROW_W(ROW_W), .TEST_ON_RESET(TEST_ON_RESET)) uDp (
    .clk(clk), .rstN(rstN), .ev(ev), .rowAddr(rowAddr),
    .evtType(evtQ), .refreshRow(refreshRow), .testMode(testMode), .outEn(outEn)
  );

  assign evtType = evtQ;

  a_r10_cas_high_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    $past(casN) |-> !outEn);
  a_r10_oe_high_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    $past(oeN) |-> !outEn);
endmodule

// File: tb/dramCycleDecoder_test.sv
module dramCycleDecoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [W-1:0] rowAddr = '0;
  logic [2:0] evtType;
  logic [W-1:0] refreshRow;
  logic testMode, outEn;

  int total = 0;
  int bad = 0;
  bit done = 0;

  dramCycleDecoder uut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .rowAddr(rowAddr), .evtType(evtType), .refreshRow(refreshRow),
    .testMode(testMode), .outEn(outEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit pR = 1, pC = 1, pW = 1;
  bit inRow = 0, colDone = 0, holding = 0, mayLate = 0;
  int cnt = 0, heldRow = 0, mRef = 0, mType = 0;
  bit mTest = 1, mOut = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pR = 1; pC = 1; pW = 1; inRow = 0; colDone = 0; holding = 0; mayLate = 0;
      cnt = 0; heldRow = 0; mRef = 0; mType = 0; mTest = 1; mOut = 0;
    end else begin
      mType = 0;
      if (pR && !rasN) begin
        if (casN) begin inRow = 1; colDone = 0; heldRow = int'(rowAddr); end
        else if (!weN) begin mType = 7; mTest = 1; end
        else begin
          mType = holding ? 6 : 5;
          mRef = cnt; cnt = (cnt + 1) % 1024; mTest = 0;
        end
      end else if (!pR && rasN) begin
        if (inRow && !colDone) begin mType = 4; mRef = heldRow; mTest = 0; end
        inRow = 0;
      end
      if (pC && !casN && inRow && !rasN) begin
        colDone = 1;
        if (!pW) mType = 2;
        else begin
          mType = 1; holding = 1; mayLate = 1;
        end
      end
      if (pW && !weN && !casN && mayLate) begin mType = 3; mayLate = 0; end
      if (!pC && casN) begin holding = 0; mayLate = 0; end
      mOut = holding && !oeN;
      pR = rasN; pC = casN; pW = weN;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("model evtType", int'(evtType), mType);
      chk("model refreshRow", int'(refreshRow), mRef);
      chk("model testMode", int'(testMode), int'(mTest));
      chk("model outEn", int'(outEn), int'(mOut));
    end
  end

  task automatic step(input logic r, input logic c, input logic w, input logic o,
                      input logic [W-1:0] a = '0);
    rasN = r; casN = c; weN = w; oeN = o; rowAddr = a;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 type", int'(evtType), 0);
    chk("R1 test", int'(testMode), 1);
    chk("R1 outEn", int'(outEn), 0);
    chk("R1 row", int'(refreshRow), 0);

    // read, OE toggle, late write
    step(0,1,1,0,10'd5);
    step(0,0,1,0);  chk("R2 read", int'(evtType), 1); chk("R2 drive", int'(outEn), 1);
    step(0,0,1,1);  chk("R10 oe high", int'(outEn), 0);
    step(0,0,1,0);  chk("R10 oe back", int'(outEn), 1);
    step(0,0,0,0);  chk("R4 late", int'(evtType), 3); chk("R4 keeps data", int'(outEn), 1);
    step(0,1,1,1);  chk("R10 cas high", int'(outEn), 0);
    step(1,1,1,1);  chk("R11 no refresh at rise", int'(evtType), 0);
    chk("R9 read keeps test", int'(testMode), 1);

    // row-only refresh with write enable low
    step(0,1,0,1,10'h2A5);
    step(1,1,0,1);  chk("R5 ras only", int'(evtType), 4);
    chk("R5 row", int'(refreshRow), 'h2A5); chk("R9 cleared", int'(testMode), 0);
    step(1,1,1,1);

    // early write
    step(0,1,1,0,10'd3);
    step(0,1,0,0);
    step(0,0,0,0);  chk("R3 early", int'(evtType), 2); chk("R3 no drive", int'(outEn), 0);
    step(0,0,0,0);  chk("R3 still off", int'(outEn), 0);
    step(0,1,1,0);
    step(1,1,1,1);

    // page mode
    step(0,1,1,0,10'd7);
    step(0,0,1,0);  chk("R11 page read 1", int'(evtType), 1);
    step(0,1,1,0);
    step(0,0,1,0);  chk("R11 page read 2", int'(evtType), 1);
    step(0,1,0,0);
    step(0,0,0,0);  chk("R11 page early", int'(evtType), 2);
    step(0,1,1,1);
    step(1,1,1,1);  chk("R11 close", int'(evtType), 0);

    // counter refreshes
    step(1,0,1,1);
    step(0,0,1,1);  chk("R6 cbr", int'(evtType), 5); chk("R6 row0", int'(refreshRow), 0);
    step(1,1,1,1);
    step(1,0,1,1);
    step(0,0,1,1);  chk("R6 row1", int'(refreshRow), 1);
    step(1,1,1,1);

    // test entry, then cleared by counter refresh
    step(1,0,0,1);
    step(0,0,0,1);  chk("R8 entry", int'(evtType), 7); chk("R8 flag", int'(testMode), 1);
    step(1,1,1,1);
    step(1,0,1,1);
    step(0,0,1,1);  chk("R8 counter unchanged", int'(refreshRow), 2);
    chk("R9 cbr clears", int'(testMode), 0);
    step(1,1,1,1);

    // test entry then hidden refresh
    step(1,0,0,1);
    step(0,0,0,1);  chk("R8 entry again", int'(testMode), 1);
    step(1,1,1,1);
    step(0,1,1,0,10'd9);
    step(0,0,1,0);  chk("R2 read before hidden", int'(evtType), 1);
    step(1,0,1,0);  chk("R7 data kept", int'(outEn), 1);
    step(0,0,1,0);  chk("R7 hidden", int'(evtType), 6); chk("R7 row", int'(refreshRow), 3);
    chk("R7 drive", int'(outEn), 1); chk("R9 hidden clears", int'(testMode), 0);
    step(1,0,1,0);
    step(1,1,1,1);

    // simultaneous column and write falls
    step(0,1,1,0,10'd11);
    step(0,0,0,0);  chk("R4 simultaneous", int'(evtType), 3);
    step(0,1,1,1);
    step(1,1,1,1);

    // wrap
    for (int i = 4; i < 1024; i++) begin
      step(1,0,1,1);
      step(0,0,1,1);
      if (i == 1023) chk("R12 top", int'(refreshRow), 1023);
      step(1,1,1,1);
    end
    step(1,0,1,1);
    step(0,0,1,1);  chk("R12 wrap", int'(refreshRow), 0);
    step(1,1,1,1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule